// File: doc/BRIEF.md
# Serial Frequency Synthesizer Loader

This block programs an external frequency synthesizer that takes its setting as a bit-serial word over three control lines: a data line, a strobe line and a pulse line. On a start request it builds a 20-bit programme word and captures the idle level of the control lines. The word is made from a clock-select field, a feedback-divider field and a post-divider field, merged into one vector and then inverted at selected bit positions by a fixed toggle mask. A long settle wait follows, so the synthesizer can reach a known condition. Then the word goes out least significant bit first. Each bit takes two equal phases: first the data is shown with strobe high and pulse low, then pulse rises while data and strobe stay as they are.

After the last bit the control lines go back to the captured idle level, with strobe always forced high. A one-cycle done pulse marks the end of the transfer. While the transfer runs, an external-display enable output is held high. Once the block is idle, that output follows its input again, so a mode that was off before the transfer is off again afterwards. Both wait lengths are given in microseconds and turned into system-clock cycles from a clock-rate parameter. The divider values arrive ready-made at the ports.

Top module: `synth_serial_loader`

## Requirements
- R1: The programme word is (clkSel << 0) | (fbDiv << 4) | (postDiv << 13), 20 bits wide, XORed with the toggle mask 20'h48102. These are the default field positions and the default mask.
- R2: Exactly 20 bits are sent, bit 0 first, one bit per period of two phases.
- R3: The first bit is presented SETTLE_CYC cycles after the clock edge that samples start. Until then the control lines keep the values they had before start.
- R4: In each bit period the data line carries the bit with strobe 1 and pulse 0 for PHASE_CYC cycles. Pulse is then 1 for PHASE_CYC more cycles, with data and strobe unchanged.
- R5: On the edge that ends the last pulse phase, the control lines take the idle value sampled at start, encoded as {pulse, strobe, data} = idleCtl[2:0], with strobe forced to 1. On that same edge busy falls and done is 1 for exactly one cycle.
- R6: extDispOut is 1 whenever busy is 1. Otherwise it equals extDispIn.
- R7: A start that arrives while busy is 1 is ignored. The bits being sent, the timing and the restored idle value all stay unchanged, even if the field and idle inputs change.
- R8: Reset, asynchronous and active low, sets busy = 0 and done = 0, and sets the control lines to {pulse, strobe, data} = 3'b010. It also aborts any transfer in progress.
- R9: SETTLE_CYC = CLK_KHZ*SETTLE_US/1000 and PHASE_CYC = CLK_KHZ*PHASE_US/1000, each at least 1.
- R10: A start given in the cycle where done is 1 is accepted and begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| clkSel | input | 4 | Clock-select field |
| fbDiv | input | 9 | Feedback-divider field |
| postDiv | input | 2 | Post-divider field |
| idleCtl | input | 3 | Idle level of the lines, {pulse, strobe, data} |
| extDispIn | input | 1 | Current external-display enable |
| serData | output | 1 | Serial data line |
| serStrobe | output | 1 | Strobe line |
| serPulse | output | 1 | Clock pulse line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| extDispOut | output | 1 | External-display enable driven during the transfer |

## Verification
A wrong phase timer shows on the pulse line within one bit period, as a pulse edge that comes early or late against the cycle count taken from start. A wrong bit counter or shift register shows as a wrong bit value sampled at a pulse rise, or as a transfer that ends too early or too late, seen at done and busy. If the start guard is broken, a start given during a transfer restarts the settle wait at once, and the pulse line goes quiet where a pulse is expected. A wrong saved idle value shows at the single edge where the lines are restored.

// File: rtl/synthload_pkg.sv
package synthload_pkg;

  // Command strobes from the sequencer to the datapath, at most one per cycle.
  typedef struct packed {
    logic load;     // capture the programme word and the idle line level
    logic present;  // drive the current bit, strobe high, pulse low
    logic raise;    // raise pulse, advance the shift register
    logic restore;  // return the lines to the captured idle level
  } loadStb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LOW,
    ST_HIGH
  } loadState_e;

endpackage

// File: rtl/synthload_dp.sv
module synthload_dp
  import synthload_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int SEL_W = 4,
  parameter int SEL_LSB = 0,
  parameter int FB_W = 9,
  parameter int FB_LSB = 4,
  parameter int PD_W = 2,
  parameter int PD_LSB = 13,
  parameter logic [WORD_W-1:0] TOGGLE_MASK = 20'h48102
) (
  input  logic             clk,
  input  logic             rstN,
  input  loadStb_t         stb,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [FB_W-1:0]  fbDiv,
  input  logic [PD_W-1:0]  postDiv,
  input  logic [2:0]       idleCtl,
  output logic             serData,
  output logic             serStrobe,
  output logic             serPulse
);

  localparam logic [2:0] STROBE_ONLY = 3'b010;

  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] shReg;
  logic [2:0]        savedIdle;

  // Field merge, then inversion of the masked bit positions.
  always_comb begin
    txWord = (WORD_W'(clkSel) << SEL_LSB)
           | (WORD_W'(fbDiv)  << FB_LSB)
           | (WORD_W'(postDiv) << PD_LSB);
    txWord = txWord ^ TOGGLE_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      savedIdle <= STROBE_ONLY;
      serData   <= 1'b0;
      serStrobe <= 1'b1;
      serPulse  <= 1'b0;
    end else begin
      if (stb.load) begin
        shReg     <= txWord;
        savedIdle <= idleCtl;
      end
      if (stb.present) begin
        serData   <= shReg[0];
        serStrobe <= 1'b1;
        serPulse  <= 1'b0;
      end
      if (stb.raise) begin
        serPulse <= 1'b1;
        shReg    <= shReg >> 1;
      end
      if (stb.restore) begin
        {serPulse, serStrobe, serData} <= savedIdle | STROBE_ONLY;
      end
    end
  end

  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    serPulse |-> serStrobe); // R4

  AST_DATA_HELD_AT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serPulse) |-> $stable(serData)); // R4

endmodule

// File: rtl/synthload_ctl.sv
module synthload_ctl
  import synthload_pkg::*;
#(
  parameter int NBITS = 20,
  parameter int SETTLE_CYC = 12500000,
  parameter int PHASE_CYC = 6500
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output loadStb_t stb,
  output logic     busy,
  output logic     done
);

  localparam int MAX_CYC = (SETTLE_CYC > PHASE_CYC) ? SETTLE_CYC : PHASE_CYC;
  localparam int TMR_W = $clog2(MAX_CYC) + 1;
  localparam int CNT_W = (NBITS > 2) ? $clog2(NBITS) : 1;

  loadState_e       state, stateNext;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] bitCnt;
  logic             timerZero;
  logic             lastBit;

  assign timerZero = (timer == '0);
  assign lastBit   = (bitCnt == CNT_W'(NBITS - 1));
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.load  = 1'b1;
          stateNext = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (timerZero) begin
          stb.present = 1'b1;
          stateNext   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (timerZero) begin
          stb.raise = 1'b1;
          stateNext = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (timerZero) begin
          if (lastBit) begin
            stb.restore = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            stb.present = 1'b1;
            stateNext   = ST_LOW;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= stb.restore;
      if (stb.load) begin
        timer  <= TMR_W'(SETTLE_CYC - 1);
        bitCnt <= '0;
      end else if (stb.present || stb.raise) begin
        timer <= TMR_W'(PHASE_CYC - 1);
      end else if (!timerZero) begin
        timer <= timer - 1'b1;
      end
      if (state == ST_HIGH && timerZero && !lastBit) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_BITCNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(NBITS - 1)); // R2

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOW && start) |=> (state != ST_SETTLE)); // R7

endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import synthload_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 250000,
  parameter int unsigned SETTLE_US = 50000,
  parameter int unsigned PHASE_US = 26,
  parameter int WORD_W = 20,
  parameter int SEL_W = 4,
  parameter int SEL_LSB = 0,
  parameter int FB_W = 9,
  parameter int FB_LSB = 4,
  parameter int PD_W = 2,
  parameter int PD_LSB = 13,
  parameter logic [WORD_W-1:0] TOGGLE_MASK = 20'h48102
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [FB_W-1:0]  fbDiv,
  input  logic [PD_W-1:0]  postDiv,
  input  logic [2:0]       idleCtl,
  input  logic             extDispIn,
  output logic             serData,
  output logic             serStrobe,
  output logic             serPulse,
  output logic             busy,
  output logic             done,
  output logic             extDispOut
);

  localparam longint unsigned SETTLE_RAW = longint'(CLK_KHZ) * longint'(SETTLE_US) / 1000;
  localparam longint unsigned PHASE_RAW  = longint'(CLK_KHZ) * longint'(PHASE_US) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
  localparam int PHASE_CYC  = (PHASE_RAW < 1) ? 1 : int'(PHASE_RAW);

  loadStb_t stb;

  synthload_ctl #(
    .NBITS(WORD_W),
    .SETTLE_CYC(SETTLE_CYC),
    .PHASE_CYC(PHASE_CYC)
  ) uCtl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stb  (stb),
    .busy (busy),
    .done (done)
  );

  synthload_dp #(
    .WORD_W(WORD_W),
    .SEL_W(SEL_W),
    .SEL_LSB(SEL_LSB),
    .FB_W(FB_W),
    .FB_LSB(FB_LSB),
    .PD_W(PD_W),
    .PD_LSB(PD_LSB),
    .TOGGLE_MASK(TOGGLE_MASK)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .clkSel   (clkSel),
    .fbDiv    (fbDiv),
    .postDiv  (postDiv),
    .idleCtl  (idleCtl),
    .serData  (serData),
    .serStrobe(serStrobe),
    .serPulse (serPulse)
  );

  // Display mode held on for the whole transfer, then handed back.
  assign extDispOut = extDispIn | busy;

  AST_IDLE_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (serStrobe && done)); // R5

endmodule

// File: tb/tb_synth_serial_loader.sv
module tb_synth_serial_loader;

  localparam int SET = 20;   // 1000 kHz * 20 us / 1000
  localparam int PH  = 3;    // 1000 kHz * 3 us / 1000
  localparam int END = SET + 40 * PH;
  localparam logic [19:0] MASK = 20'h48102;

  // {clkSel[4], fbDiv[9], postDiv[2], idleCtl[3], extDispIn, startWhileBusy}
  localparam int NVEC = 5;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'h5, 9'h1A3, 2'd2, 3'b101, 1'b0, 1'b0},
    {4'h0, 9'h000, 2'd0, 3'b000, 1'b1, 1'b0},
    {4'hF, 9'h1FF, 2'd3, 3'b111, 1'b0, 1'b1},
    {4'hA, 9'h055, 2'd1, 3'b100, 1'b1, 1'b1},
    {4'h3, 9'h100, 2'd0, 3'b010, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] clkSel = '0;
  logic [8:0] fbDiv = '0;
  logic [1:0] postDiv = '0;
  logic [2:0] idleCtl = '0;
  logic extDispIn = 1'b0;
  logic serData, serStrobe, serPulse, busy, done, extDispOut;

  int checks = 0;
  int failures = 0;
  logic [2:0] prevCtl = 3'b010;

  always #2 clk = ~clk;

  synth_serial_loader #(
    .CLK_KHZ(1000),
    .SETTLE_US(20),
    .PHASE_US(3)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .clkSel(clkSel), .fbDiv(fbDiv),
    .postDiv(postDiv), .idleCtl(idleCtl), .extDispIn(extDispIn),
    .serData(serData), .serStrobe(serStrobe), .serPulse(serPulse),
    .busy(busy), .done(done), .extDispOut(extDispOut)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] makeWord(logic [3:0] s, logic [8:0] f, logic [1:0] p);
    return ((20'(s) << 0) | (20'(f) << 4) | (20'(p) << 13)) ^ MASK;
  endfunction

  // Entered at a negedge; leaves at the negedge of the done cycle.
  task automatic runXfer(input logic [19:0] v, input string tag);
    logic [19:0] expWord, got;
    logic [2:0] idle0, expCtl, obs, restoreExp, restoreGot;
    int errSettle, errStream, errBusy, errDone, firstBad;
    logic [2:0] firstAct, firstExp;
    logic chg;
    logic doneAtStart;
    {clkSel, fbDiv, postDiv, idleCtl, extDispIn, chg} = v;
    idle0 = idleCtl;
    expWord = makeWord(clkSel, fbDiv, postDiv);
    restoreExp = idle0 | 3'b010;
    got = '0; errSettle = 0; errStream = 0; errBusy = 0; errDone = 0;
    firstBad = -1; firstAct = '0; firstExp = '0; restoreGot = '0;
    doneAtStart = done;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= END; k++) begin
      if (k > 0) @(negedge clk);
      obs = {serPulse, serStrobe, serData};
      if (chg && k == 30) begin
        start = 1'b1; clkSel = ~clkSel; fbDiv = ~fbDiv; postDiv = ~postDiv;
        idleCtl = ~idleCtl;
      end
      if (chg && k == 31) start = 1'b0;
      if (k < SET) begin
        if (obs != prevCtl) errSettle++;
      end else if (k < END) begin
        int ph, b;
        ph = (k - SET) / PH;
        b = ph / 2;
        expCtl = {logic'(ph % 2), 1'b1, expWord[b]};
        if (ph % 2 == 1) got[b] = serData;
        if (obs != expCtl) begin
          errStream++;
          if (firstBad < 0) begin firstBad = k; firstAct = obs; firstExp = expCtl; end
        end
      end else begin
        restoreGot = obs;
      end
      if (k < END) begin
        if (!busy || !extDispOut) errBusy++;
        if (done) errDone++;
      end
    end
    check(errSettle == 0, {tag, " R3 R9 lines held during settle"}, errSettle, 0);
    check(errStream == 0, {tag, " R2 R4 bit phase shape"}, {firstAct, 8'(firstBad)}, {firstExp, 8'(firstBad)});
    check(got == expWord, {tag, " R1 word sampled at pulse high"}, got, expWord);
    check(restoreGot == restoreExp, {tag, " R5 restored idle lines"}, restoreGot, restoreExp);
    check(done && !busy && errDone == 0, {tag, " R5 done pulse and busy fall"}, {done, busy}, 2'b10);
    check(errBusy == 0 && extDispOut == extDispIn, {tag, " R6 display enable"}, errBusy, 0);
    if (chg) check(got == expWord && restoreGot == restoreExp, {tag, " R7 start while busy ignored"},
                   restoreGot, restoreExp);
    if (doneAtStart) check(errSettle == 0 && got == expWord, {tag, " R10 start in done cycle"}, got, expWord);
    prevCtl = restoreExp;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done, "R8 reset busy/done", {busy, done}, 0);
    check({serPulse, serStrobe, serData} == 3'b010, "R8 reset lines",
          {serPulse, serStrobe, serData}, 3'b010);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) runXfer(VEC[i], $sformatf("vec%0d", i));
    // Abort by reset in the middle of a transfer.
    @(negedge clk);
    extDispIn = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (45) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!busy && !done && extDispOut == extDispIn, "R8 reset mid-transfer busy", {busy, done}, 0);
    check({serPulse, serStrobe, serData} == 3'b010, "R8 reset mid-transfer lines",
          {serPulse, serStrobe, serData}, 3'b010);
    rstN = 1'b1;
    prevCtl = 3'b010;
    @(negedge clk);
    runXfer(VEC[0], "afterReset");
    @(negedge clk);
    check(!done && !busy, "R5 done lasts one cycle", {done, busy}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule